// File: doc/BRIEF.md
# Indexed Configuration Space Controller

This block gives a host a byte-wide configuration space reached through a pair of I/O ports: an index port that holds a register number and a data port that reads or writes the register so numbered. A strap input chooses the port pair. With the strap low the pair is 0x2E (index) and 0x2F (data). With the strap high it is 0x4E and 0x4F. Registers 0x00 to 0x2F form a global area shared by all logical devices. This area holds a device-select register, a fixed chip identifier and a fixed revision code.

Registers 0x30 and above are banked. The device-select register picks which logical device's bank is visible there. Each device has an activate flag and a 16-bit I/O base. Both drive the peripherals through the output buses `ld_active` and `ld_base`. Each peripheral decodes a 16-byte window at its base. Registers 0xF0 to 0xFF are not stored here. An access to one of them is forwarded on a side-band strobe port to the selected device, and the device's returned byte goes back on the data port.

The host interface has plain strobes and no back-pressure. A write takes effect at the clock edge where `host_wr` is sampled high. Read data is combinational and is valid in the same cycle that `host_rd` is high. If both strobes are high, the write wins and the read is ignored.

Top module: `cfg_space_ctrl`

## Requirements
- R1: With `strap_alt`=0 the block answers only at addresses 0x2E (index) and 0x2F (data). With `strap_alt`=1 it answers only at 0x4E and 0x4F. `host_hit` is high exactly when a strobe is present at one of the two active addresses. Accesses at any other address change no state.
- R2: A write to the index port stores the full byte as the current register number, and a read of the index port returns it. After reset the index is 0x00.
- R3: A data port read or write acts on the register numbered by the last index write.
- R4: Register 0x20 reads 0xE9 and register 0x21 reads the revision value 0x01. Writes to either register leave their read values unchanged.
- R5: Register 0x07 is the device-select register. A write stores the low 4 bits of the data, and a read returns them zero-extended. The stored value selects the bank seen at registers 0x30 and above.
- R6: Bit 0 of register 0x30 is the activate flag of the selected device, and a read returns it with bits 7..1 zero. `ld_active[n]` is the flag of device n and changes in the cycle after the write.
- R7: Register 0x60 holds bits 15..8 and register 0x61 holds bits 7..0 of the selected device's I/O base. `ld_base[16n+15:16n]` is the base of device n and changes in the cycle after the write.
- R8: Reads of any other register below 0xF0 return 0xFF, and writes to them are ignored. When the selected device number is 15 or more (no such device), accesses to registers 0x30, 0x60 and 0x61 also read 0xFF and write nothing.
- R9: For registers 0xF0 to 0xFF with a valid device selected, a data access raises `dev_wr` or `dev_rd` in the same cycle. `dev_reg` carries bits 3..0 of the index, `dev_ldn` carries the selected device and `dev_wdata` carries the write data. A read returns `dev_rdata`. With no valid device selected, these registers raise no strobe and read 0xFF.
- R10: After reset all devices are inactive and all bases are 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_alt | input | 1 | Port pair select: 0 selects 0x2E/0x2F, 1 selects 0x4E/0x4F |
| host_addr | input | 16 | Host I/O address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, 0xFF when no read hits |
| host_hit | output | 1 | Strobe present at an active port address |
| ld_active | output | 15 | Activate flag per logical device |
| ld_base | output | 240 | 16-bit I/O base per logical device, device n in bits 16n+15..16n |
| dev_ldn | output | 4 | Selected device number for side-band accesses |
| dev_reg | output | 4 | Device-specific register offset (index bits 3..0) |
| dev_wr | output | 1 | Side-band write strobe |
| dev_rd | output | 1 | Side-band read strobe |
| dev_wdata | output | 8 | Side-band write data |
| dev_rdata | input | 8 | Data returned by the selected device |

## Verification
The hardest situation to reach is an access to the banked or forwarded registers while the device-select register holds 15, a number with no device. Reaching it takes three host accesses in order: an index write of 0x07, a data write of 15, and then an index write to the target register before the data access. The stimulus also swaps the strap in the middle of the run. It then writes at the port pair that has just become inactive, which shows that the decode follows the strap from one cycle to the next. Every device's bank is first loaded with a distinct pattern. This way a write that strays into the wrong bank shows up on `ld_base` at once.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int IO_BASE_W = 16;

  localparam logic [7:0] REG_LDSEL   = 8'h07;
  localparam logic [7:0] REG_CHIPID  = 8'h20;
  localparam logic [7:0] REG_REVID   = 8'h21;
  localparam logic [7:0] REG_ACTIVE  = 8'h30;
  localparam logic [7:0] REG_BASE_HI = 8'h60;
  localparam logic [7:0] REG_BASE_LO = 8'h61;

  typedef enum logic [2:0] {
    K_NONE, K_LDSEL, K_CHIPID, K_REVID, K_ACTIVE, K_BASE_HI, K_BASE_LO, K_DEVICE
  } reg_kind_e;

  function automatic reg_kind_e classify(input logic [7:0] r);
    reg_kind_e k;
    if (r[7:4] == 4'hF) k = K_DEVICE;
    else begin
      case (r)
        REG_LDSEL:   k = K_LDSEL;
        REG_CHIPID:  k = K_CHIPID;
        REG_REVID:   k = K_REVID;
        REG_ACTIVE:  k = K_ACTIVE;
        REG_BASE_HI: k = K_BASE_HI;
        REG_BASE_LO: k = K_BASE_LO;
        default:     k = K_NONE;
      endcase
    end
    return k;
  endfunction
endpackage

// File: rtl/cfg_port_decode.sv
module cfg_port_decode #(
  parameter int         ADDR_W   = 16,
  parameter logic [15:0] BASE_PRI = 16'h002E,
  parameter logic [15:0] BASE_ALT = 16'h004E
) (
  input  logic              strap_alt,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  output logic              hit,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              data_wr,
  output logic              data_rd
);
  logic [ADDR_W-1:0] base;
  logic is_idx, is_dat, rd_eff;

  always_comb begin
    base   = strap_alt ? ADDR_W'(BASE_ALT) : ADDR_W'(BASE_PRI);
    is_idx = (host_addr == base);
    is_dat = (host_addr == base + ADDR_W'(1));
    rd_eff = host_rd & ~host_wr;
    hit    = (host_wr | host_rd) & (is_idx | is_dat);
    idx_wr  = host_wr & is_idx;
    data_wr = host_wr & is_dat;
    idx_rd  = rd_eff & is_idx;
    data_rd = rd_eff & is_dat;
  end
endmodule

// File: rtl/cfg_ld_bank.sv
module cfg_ld_bank
  import cfg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel,
  input  logic                 wr,
  input  reg_kind_e            kind,
  input  logic [7:0]           wdata,
  output logic                 active,
  output logic [IO_BASE_W-1:0] base
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
    end else if (wr && sel) begin
      case (kind)
        K_ACTIVE:  active     <= wdata[0];
        K_BASE_HI: base[15:8] <= wdata;
        K_BASE_LO: base[7:0]  <= wdata;
        default: ;
      endcase
    end
  end

  // R6 R7: an unselected bank holds its contents
  p_bank_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel) |=> ($stable(active) && $stable(base)));
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_pkg::*;
#(
  parameter int         LDN_W   = 4,
  parameter logic [7:0] CHIP_ID = 8'hE9,
  parameter logic [7:0] REV_ID  = 8'h01
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idx_rd,
  input  logic                 data_rd,
  input  logic [7:0]           index,
  input  reg_kind_e            kind,
  input  logic [LDN_W-1:0]     ldn,
  input  logic                 ldn_ok,
  input  logic                 sel_active,
  input  logic [IO_BASE_W-1:0] sel_base,
  input  logic [7:0]           dev_rdata,
  output logic [7:0]           rdata
);
  logic [7:0] reg_val;

  always_comb begin
    case (kind)
      K_LDSEL:   reg_val = 8'(ldn);
      K_CHIPID:  reg_val = CHIP_ID;
      K_REVID:   reg_val = REV_ID;
      K_ACTIVE:  reg_val = ldn_ok ? {7'b0, sel_active} : 8'hFF;
      K_BASE_HI: reg_val = ldn_ok ? sel_base[15:8] : 8'hFF;
      K_BASE_LO: reg_val = ldn_ok ? sel_base[7:0] : 8'hFF;
      K_DEVICE:  reg_val = ldn_ok ? dev_rdata : 8'hFF;
      default:   reg_val = 8'hFF;
    endcase
    if (idx_rd)       rdata = index;
    else if (data_rd) rdata = reg_val;
    else              rdata = 8'hFF;
  end

  p_chip_id_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && index == REG_CHIPID) |-> (rdata == CHIP_ID));
  p_unimpl_ff_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && index == 8'h31) |-> (rdata == 8'hFF));
endmodule

// File: rtl/cfg_space_ctrl.sv
module cfg_space_ctrl
  import cfg_pkg::*;
#(
  parameter int         NUM_LD  = 15,
  parameter int         ADDR_W  = 16,
  parameter logic [7:0] CHIP_ID = 8'hE9,
  parameter logic [7:0] REV_ID  = 8'h01,
  localparam int        LDN_W   = $clog2(NUM_LD + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        strap_alt,
  input  logic [ADDR_W-1:0]           host_addr,
  input  logic                        host_wr,
  input  logic                        host_rd,
  input  logic [7:0]                  host_wdata,
  output logic [7:0]                  host_rdata,
  output logic                        host_hit,
  output logic [NUM_LD-1:0]           ld_active,
  output logic [NUM_LD*IO_BASE_W-1:0] ld_base,
  output logic [LDN_W-1:0]            dev_ldn,
  output logic [3:0]                  dev_reg,
  output logic                        dev_wr,
  output logic                        dev_rd,
  output logic [7:0]                  dev_wdata,
  input  logic [7:0]                  dev_rdata
);
  logic idx_wr, idx_rd, data_wr, data_rd;
  logic [7:0] index;
  logic [LDN_W-1:0] ldn;
  logic ldn_ok, bank_wr, sel_active;
  logic [IO_BASE_W-1:0] sel_base;
  reg_kind_e kind;

  cfg_port_decode #(.ADDR_W(ADDR_W)) u_dec (
    .strap_alt(strap_alt), .host_addr(host_addr), .host_wr(host_wr),
    .host_rd(host_rd), .hit(host_hit), .idx_wr(idx_wr), .idx_rd(idx_rd),
    .data_wr(data_wr), .data_rd(data_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index <= 8'h00;
      ldn   <= '0;
    end else begin
      if (idx_wr) index <= host_wdata;
      if (data_wr && kind == K_LDSEL) ldn <= host_wdata[LDN_W-1:0];
    end
  end

  always_comb begin
    kind    = classify(index);
    ldn_ok  = (32'(ldn) < NUM_LD);
    bank_wr = data_wr && ldn_ok &&
              (kind == K_ACTIVE || kind == K_BASE_HI || kind == K_BASE_LO);
  end

  for (genvar g = 0; g < NUM_LD; g++) begin : g_bank
    cfg_ld_bank u_bank (
      .clk(clk), .rst_n(rst_n), .sel(ldn == LDN_W'(g)), .wr(bank_wr),
      .kind(kind), .wdata(host_wdata), .active(ld_active[g]),
      .base(ld_base[g*IO_BASE_W +: IO_BASE_W])
    );
  end

  always_comb begin
    sel_active = 1'b0;
    sel_base   = '0;
    for (int i = 0; i < NUM_LD; i++) begin
      if (ldn == LDN_W'(i)) begin
        sel_active = ld_active[i];
        sel_base   = ld_base[i*IO_BASE_W +: IO_BASE_W];
      end
    end
  end

  always_comb begin
    dev_ldn   = ldn;
    dev_reg   = index[3:0];
    dev_wdata = host_wdata;
    dev_wr    = data_wr && kind == K_DEVICE && ldn_ok;
    dev_rd    = data_rd && kind == K_DEVICE && ldn_ok;
  end

  cfg_read_mux #(.LDN_W(LDN_W), .CHIP_ID(CHIP_ID), .REV_ID(REV_ID)) u_mux (
    .clk(clk), .rst_n(rst_n), .idx_rd(idx_rd), .data_rd(data_rd),
    .index(index), .kind(kind), .ldn(ldn), .ldn_ok(ldn_ok),
    .sel_active(sel_active), .sel_base(sel_base), .dev_rdata(dev_rdata),
    .rdata(host_rdata)
  );

  p_dev_needs_hit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_wr || dev_rd) |-> (host_hit && index[7:4] == 4'hF));
  p_index_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_wr |=> $stable(index));
  p_no_hit_no_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !host_hit |-> !(dev_wr || dev_rd));
endmodule

// File: tb/sim_cfg_space_ctrl.sv
`timescale 1ns/1ps
module sim_cfg_space_ctrl;
  logic clk = 0, rst_n = 0, strap_alt = 0;
  logic [15:0] host_addr = 0;
  logic host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = 0, host_rdata, dev_wdata, dev_rdata;
  logic host_hit, dev_wr, dev_rd;
  logic [14:0] ld_active;
  logic [239:0] ld_base;
  logic [3:0] dev_ldn, dev_reg;

  int checks = 0, errors = 0;
  bit done = 0;
  int m_act[15];
  int m_base[15];
  int m_idx = 0, m_ldn = 0;

  always #10 clk = ~clk;

  assign dev_rdata = {dev_ldn, dev_reg} ^ 8'h5A;

  cfg_space_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .host_addr(host_addr),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_hit(host_hit), .ld_active(ld_active),
    .ld_base(ld_base), .dev_ldn(dev_ldn), .dev_reg(dev_reg), .dev_wr(dev_wr),
    .dev_rd(dev_rd), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata)
  );

  task automatic chk(logic [255:0] act, logic [255:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_outputs();
    logic [14:0] ea;
    logic [239:0] eb;
    for (int i = 0; i < 15; i++) begin
      ea[i] = m_act[i][0];
      eb[i*16 +: 16] = m_base[i][15:0];
    end
    chk(256'(ld_active), 256'(ea), "R6 ld_active");
    chk(256'(ld_base), 256'(eb), "R7 ld_base");
  endtask

  task automatic acc(bit wr, logic [15:0] a, logic [7:0] d);
    int base;
    bit hit_e, dat, ok, dev_e;
    logic [7:0] ev;
    string t;
    @(negedge clk);
    cmp_outputs();
    host_addr = a; host_wr = wr; host_rd = !wr; host_wdata = d;
    #2;
    base = strap_alt ? 'h4E : 'h2E;
    hit_e = (a == base) || (a == base + 1);
    dat = (a == base + 1);
    ok = m_ldn < 15;
    dev_e = hit_e && dat && m_idx >= 'hF0 && ok;
    chk(256'(host_hit), 256'(hit_e), "R1 hit");
    chk(256'({dev_wr, dev_rd}), 256'({wr && dev_e, !wr && dev_e}), "R9 strobes");
    if (dev_e) begin
      chk(256'({dev_ldn, dev_reg}), 256'({m_ldn[3:0], m_idx[3:0]}), "R9 reg");
      if (wr) chk(256'(dev_wdata), 256'(d), "R9 wdata");
    end
    if (!wr && hit_e) begin
      if (!dat) begin ev = m_idx[7:0]; t = "R2 index"; end
      else if (m_idx >= 'hF0) begin
        ev = ok ? ({m_ldn[3:0], m_idx[3:0]} ^ 8'h5A) : 8'hFF; t = "R9 read";
      end else begin
        case (m_idx)
          'h07: begin ev = m_ldn[7:0]; t = "R5 ldsel"; end
          'h20: begin ev = 8'hE9; t = "R4 chip id"; end
          'h21: begin ev = 8'h01; t = "R4 revision"; end
          'h30: begin ev = ok ? m_act[m_ldn][7:0] : 8'hFF; t = ok ? "R6 read" : "R8 no dev"; end
          'h60: begin ev = ok ? m_base[m_ldn][15:8] : 8'hFF; t = ok ? "R7 hi" : "R8 no dev"; end
          'h61: begin ev = ok ? m_base[m_ldn][7:0] : 8'hFF; t = ok ? "R7 lo" : "R8 no dev"; end
          default: begin ev = 8'hFF; t = "R8 unimpl"; end
        endcase
      end
      chk(256'(host_rdata), 256'(ev), {t, " R3"});
    end
    @(posedge clk); #1;
    host_wr = 0; host_rd = 0;
    if (wr && hit_e) begin
      if (!dat) m_idx = d;
      else begin
        case (m_idx)
          'h07: m_ldn = d & 15;
          'h30: if (ok) m_act[m_ldn] = d & 1;
          'h60: if (ok) m_base[m_ldn] = (m_base[m_ldn] & 'hFF) | (d << 8);
          'h61: if (ok) m_base[m_ldn] = (m_base[m_ldn] & 'hFF00) | d;
          default: ;
        endcase
      end
    end
  endtask

  task automatic wreg(logic [7:0] r, logic [7:0] d);
    logic [15:0] b;
    b = strap_alt ? 16'h4E : 16'h2E;
    acc(1, b, r);
    acc(1, b + 1, d);
  endtask

  task automatic rreg(logic [7:0] r);
    logic [15:0] b;
    b = strap_alt ? 16'h4E : 16'h2E;
    acc(1, b, r);
    acc(0, b + 1, 0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 15; i++) begin m_act[i] = 0; m_base[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state of the device outputs
    chk(256'(ld_active), 256'(0), "R10 active");
    chk(256'(ld_base), 256'(0), "R10 base");
    rst_n = 1;
    acc(0, 16'h2E, 0);             // R2 index reset value
    rreg(8'h20); rreg(8'h21);      // R4
    wreg(8'h20, 8'h00); wreg(8'h21, 8'h77);
    rreg(8'h20); rreg(8'h21);
    for (int i = 0; i < 15; i++) begin
      wreg(8'h07, 8'(i));
      wreg(8'h30, 8'(i % 3 == 0 ? 8'hFF : 8'hFE));
      wreg(8'h60, 8'(8'h10 + i));
      wreg(8'h61, 8'(i * 16));
    end
    for (int i = 14; i >= 0; i -= 3) begin
      wreg(8'h07, 8'(i));
      rreg(8'h07); rreg(8'h30); rreg(8'h60); rreg(8'h61);
      rreg(8'hF0); rreg(8'hFF);
      wreg(8'hF5, 8'hC3);
    end
    // R5: only low bits of the device select are kept
    wreg(8'h07, 8'h1C); rreg(8'h07); rreg(8'h60);
    // R8: missing device 15
    wreg(8'h07, 8'h0F);
    wreg(8'h30, 8'h01); wreg(8'h60, 8'hAA); wreg(8'h61, 8'h55);
    rreg(8'h30); rreg(8'h60); rreg(8'h61); rreg(8'hF3); wreg(8'hF3, 8'h11);
    // R8: unimplemented registers
    wreg(8'h07, 8'h02);
    rreg(8'h00); rreg(8'h2F); rreg(8'h31); rreg(8'hEF);
    wreg(8'h31, 8'h00); wreg(8'h62, 8'h00); rreg(8'h31); rreg(8'h60);
    // R1: strap swap and foreign addresses
    acc(1, 16'h4E, 8'h60); acc(1, 16'h4F, 8'h99); acc(1, 16'h2D, 8'h07);
    acc(0, 16'h4F, 0); acc(0, 16'h30, 0);
    @(negedge clk); strap_alt = 1;
    acc(1, 16'h2E, 8'h61); acc(1, 16'h2F, 8'h00);
    rreg(8'h61); wreg(8'h61, 8'h3C); rreg(8'h61);
    acc(0, 16'h4E, 0);
    wreg(8'h07, 8'h05); wreg(8'h30, 8'h00); rreg(8'h30); rreg(8'hFA);
    @(negedge clk); cmp_outputs();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule